// File: doc/BRIEF.md
# ISA Peripheral Slave Port

This block is the target side of a peripheral card on a 16-bit ISA-style bus, clocked by the bus clock. While the address-latch strobe is high, it follows the system address and compares the upper address group against a configured window. The strobe's falling edge freezes both the address and that comparison for the rest of the cycle. The window is either a memory window in the 16 MB space or an I/O window in the 64 KB port space, chosen by parameter. A high DMA address-enable blocks every select.

A selected read drives the data bus from a small local register file. The low byte lane is always driven; the high lane is driven only for 16-bit transfers. A selected write stores into that register file. The card can stretch a cycle by pulling the ready line low for a fixed number of bus clocks. In memory mode with no wait states, it instead raises a zero-wait-state request. A local event raises an interrupt request that stays high until software writes the clear register. Tri-state drivers are modelled as separate enable outputs.

Top module: `isa_slave_port`

## Requirements
- R1: The system address (20 bits) and the upper-group match (bits 23..17) are tracked while `addr_strobe` is high and frozen at its falling edge. Changes on `sys_addr` or `upper_addr` after that edge do not alter the select or the register index.
- R2: In memory mode a command on `mem_rd_n`/`mem_wr_n` (active low) selects the card exactly when the 24-bit address {upper_addr, sys_addr[16:0]} lies in [BASE_ADDR, BASE_ADDR+NREG).
- R3: In I/O mode a command on `io_rd_n`/`io_wr_n` (active low) selects the card exactly when sys_addr[15:0] lies in [BASE_ADDR[15:0], BASE_ADDR[15:0]+NREG). Bits 19..16 are ignored, and memory strobes never select an I/O card.
- R4: While `dma_active` is high, the card drives no data, pulls no ready, raises no zero-wait request and stores no write.
- R5: When WAIT_CLKS>0, `ready_pull` rises in the same cycle a selected command appears and stays high for exactly WAIT_CLKS clocks. It then stays low until the command ends.
- R6: `zero_wait_req` is high during a selected memory command only when WAIT_CLKS is 0. It is never high in I/O mode.
- R7: During a selected read, `data_oe_lo` is high and `data_out[7:0]` holds register[idx] bits 7..0. `data_oe_hi` and bits 15..8 follow only when `wide_xfer` is high. Both enables stay high until the read strobe goes high, then drop.
- R8: A selected write stores `data_in` into register idx = latched sys_addr[IDXW-1:0] at the clock that ends the wait. A narrow write (`wide_xfer` low) changes only bits 7..0.
- R9: A high `irq_event` clock sets `irq_req`, which stays high until a write to index CLR_IDX. The clear wins over a simultaneous event, so the line is low for at least one clock before re-arming.
- R10: After reset, all enables, `ready_pull`, `zero_wait_req` and `irq_req` are low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strobe | input | 1 | Address latch strobe; address frozen on its fall |
| sys_addr | input | 20 | System address, bit 19 most significant |
| upper_addr | input | 7 | Upper memory address bits 23..17, valid while strobe high |
| dma_active | input | 1 | DMA address enable; high blocks select |
| mem_rd_n | input | 1 | Memory read command, active low |
| mem_wr_n | input | 1 | Memory write command, active low |
| io_rd_n | input | 1 | I/O read command, active low |
| io_wr_n | input | 1 | I/O write command, active low |
| wide_xfer | input | 1 | High for a 16-bit transfer, low for 8-bit |
| data_in | input | DW | Data bus as seen by the card |
| data_out | output | DW | Data the card drives on reads |
| data_oe_lo | output | 1 | Drive enable, byte lane 7..0 |
| data_oe_hi | output | 1 | Drive enable, byte lane 15..8 |
| ready_pull | output | 1 | High pulls the ready line low (wait state) |
| zero_wait_req | output | 1 | Zero-wait-state request for a memory cycle |
| irq_event | input | 1 | Local interrupt event |
| irq_req | output | 1 | Interrupt request line |

## Verification
The bench builds a memory card with no wait states and an I/O card with three wait states on one shared bus. It sweeps addresses across each window edge and flips single bits in the upper group, the low group and the ignored I/O bits. This separates a correct range compare from one that ignores a bit group. Address lines are scrambled right after the strobe falls, which exposes any decode that is not frozen. Wide and narrow writes and reads tell the two byte lanes apart. A DMA-flagged write followed by a readback shows that a blocked select stores nothing. Interrupt events before and after the clear write separate hold, clear and re-arm.

// File: rtl/isa_slv_pkg.sv
package isa_slv_pkg;
    localparam int SA_W = 20;
    localparam int LA_W = 7;
    localparam int CNT_W = 4;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_WAIT = 2'd1,
        WS_DONE = 2'd2
    } ws_state_e;
endpackage

// File: rtl/isa_addr_capture.sv
module isa_addr_capture
    import isa_slv_pkg::*;
#(
    parameter bit          IS_MEM    = 1'b1,
    parameter logic [23:0] BASE_ADDR = 24'h345670,
    parameter int          IDXW      = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strobe,
    input  logic [SA_W-1:0] sys_addr,
    input  logic [LA_W-1:0] upper_addr,
    output logic            hit,
    output logic [IDXW-1:0] idx
);
    typedef struct packed {
        logic [SA_W-1:0] sa;
        logic            up_ok;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (strobe) begin
            cap_d.sa    = sys_addr;
            cap_d.up_ok = (upper_addr == BASE_ADDR[23:17]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    generate
        if (IS_MEM) begin : g_mem
            assign hit = cap_q.up_ok && (cap_q.sa[16:IDXW] == BASE_ADDR[16:IDXW]);
        end else begin : g_io
            assign hit = (cap_q.sa[15:IDXW] == BASE_ADDR[15:IDXW]);
        end
    endgenerate

    assign idx = cap_q.sa[IDXW-1:0];

    // R1: once the strobe is low, the captured state does not move
    assert_hold_after_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !$past(strobe)) |-> ($stable(cap_q.sa) && $stable(cap_q.up_ok)));
endmodule

// File: rtl/isa_wait_ctl.sv
module isa_wait_ctl
    import isa_slv_pkg::*;
#(
    parameter int WAIT_CLKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_sel,
    output logic rdy_pull,
    output logic fire
);
    localparam logic [CNT_W-1:0] WL = CNT_W'(WAIT_CLKS);

    typedef struct packed {
        ws_state_e        st;
        logic [CNT_W-1:0] cnt;
    } ws_t;

    ws_t ws_d, ws_q;

    always_comb begin
        ws_d     = ws_q;
        rdy_pull = 1'b0;
        fire     = 1'b0;
        case (ws_q.st)
            WS_IDLE: begin
                if (cmd_sel) begin
                    if (WAIT_CLKS == 0) begin
                        ws_d.st = WS_DONE;
                        fire    = 1'b1;
                    end else begin
                        rdy_pull = 1'b1;
                        if (WAIT_CLKS == 1) begin
                            ws_d.st = WS_DONE;
                            fire    = 1'b1;
                        end else begin
                            ws_d.st  = WS_WAIT;
                            ws_d.cnt = WL - 1'b1;
                        end
                    end
                end
            end
            WS_WAIT: begin
                if (!cmd_sel) begin
                    ws_d.st = WS_IDLE;
                end else begin
                    rdy_pull = 1'b1;
                    if (ws_q.cnt == CNT_W'(1)) begin
                        ws_d.st = WS_DONE;
                        fire    = 1'b1;
                    end else begin
                        ws_d.cnt = ws_q.cnt - 1'b1;
                    end
                end
            end
            WS_DONE: begin
                if (!cmd_sel) ws_d.st = WS_IDLE;
            end
            default: ws_d.st = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ws_q <= '{st: WS_IDLE, cnt: '0};
        else        ws_q <= ws_d;
    end

    // R5: once released inside a command, ready is not pulled again
    assert_no_repull_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_sel && $past(cmd_sel) && !$past(rdy_pull)) |-> !rdy_pull);
endmodule

// File: rtl/isa_regfile.sv
module isa_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 8,
    parameter int IDXW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic            wide,
    input  logic [IDXW-1:0] idx,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata
);
    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (we) begin
            rf_d.regs[idx][7:0] = wdata[7:0];
            if (wide) rf_d.regs[idx][DW-1:8] = wdata[DW-1:8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign rdata = rf_q.regs[idx];
endmodule

// File: rtl/isa_irq_ctl.sv
module isa_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic event_in,
    input  logic clr,
    output logic irq
);
    typedef struct packed {
        logic line;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (clr)                         irq_d.line = 1'b0;
        else if (event_in && !irq_q.line) irq_d.line = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q.line;

    // R9: a raised request stays up until a clear write
    assert_irq_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_q.line) && !$past(clr)) |-> irq_q.line);
endmodule

// File: rtl/isa_slave_port.sv
module isa_slave_port
    import isa_slv_pkg::*;
#(
    parameter bit          IS_MEM    = 1'b1,
    parameter logic [23:0] BASE_ADDR = 24'h345670,
    parameter int          DW        = 16,
    parameter int          NREG      = 8,
    parameter int          WAIT_CLKS = 0,
    parameter int          CLR_IDX   = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_strobe,
    input  logic [19:0]   sys_addr,
    input  logic [6:0]    upper_addr,
    input  logic          dma_active,
    input  logic          mem_rd_n,
    input  logic          mem_wr_n,
    input  logic          io_rd_n,
    input  logic          io_wr_n,
    input  logic          wide_xfer,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] data_out,
    output logic          data_oe_lo,
    output logic          data_oe_hi,
    output logic          ready_pull,
    output logic          zero_wait_req,
    input  logic          irq_event,
    output logic          irq_req
);
    localparam int IDXW = $clog2(NREG);
    localparam logic [IDXW-1:0] CLR_I = IDXW'(CLR_IDX);

    logic            hit;
    logic [IDXW-1:0] idx;
    logic            rd_cmd, wr_cmd, sel, cmd_sel, fire, we, clr;
    logic [DW-1:0]   rdata;

    isa_addr_capture #(.IS_MEM(IS_MEM), .BASE_ADDR(BASE_ADDR), .IDXW(IDXW)) u_cap (
        .clk(clk), .rst_n(rst_n), .strobe(addr_strobe), .sys_addr(sys_addr),
        .upper_addr(upper_addr), .hit(hit), .idx(idx)
    );

    assign rd_cmd  = IS_MEM ? !mem_rd_n : !io_rd_n;
    assign wr_cmd  = IS_MEM ? !mem_wr_n : !io_wr_n;
    assign sel     = hit && !dma_active;
    assign cmd_sel = sel && (rd_cmd || wr_cmd);

    isa_wait_ctl #(.WAIT_CLKS(WAIT_CLKS)) u_wait (
        .clk(clk), .rst_n(rst_n), .cmd_sel(cmd_sel), .rdy_pull(ready_pull), .fire(fire)
    );

    assign we  = fire && sel && wr_cmd;
    assign clr = we && (idx == CLR_I);

    isa_regfile #(.DW(DW), .NREG(NREG), .IDXW(IDXW)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(we), .wide(wide_xfer), .idx(idx),
        .wdata(data_in), .rdata(rdata)
    );

    isa_irq_ctl u_irq (
        .clk(clk), .rst_n(rst_n), .event_in(irq_event), .clr(clr), .irq(irq_req)
    );

    assign data_oe_lo    = sel && rd_cmd;
    assign data_oe_hi    = data_oe_lo && wide_xfer;
    assign data_out      = {(data_oe_hi ? rdata[DW-1:8] : '0), (data_oe_lo ? rdata[7:0] : 8'h00)};
    assign zero_wait_req = IS_MEM && (WAIT_CLKS == 0) && cmd_sel;

    // R4: a DMA cycle never sees this card respond
    assert_dma_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_active |-> (!data_oe_lo && !ready_pull && !zero_wait_req));

    // R7: the high lane is never driven alone
    assert_hi_needs_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_hi |-> data_oe_lo);
endmodule

// File: tb/isa_slave_port_test.sv
module isa_slave_port_test;
    localparam logic [23:0] MBASE = 24'h345670;
    localparam logic [23:0] IBASE = 24'h000300;

    logic clk = 0, rst_n = 0;
    logic bale = 0, dma = 0, mrd = 1, mwr = 1, ird = 1, iwr = 1, wide = 1;
    logic [19:0] sa = 0;
    logic [6:0]  la = 0;
    logic [15:0] sd_in = 0;
    logic ev_m = 0, ev_i = 0;
    logic [15:0] dout_m, dout_i;
    logic oel_m, oeh_m, pull_m, zws_m, irq_m;
    logic oel_i, oeh_i, pull_i, zws_i, irq_i;
    int total = 0, bad = 0;
    logic [15:0] exp_m [8];
    logic [15:0] exp_i [8];

    always #2 clk = ~clk;

    isa_slave_port #(.IS_MEM(1'b1), .BASE_ADDR(MBASE), .WAIT_CLKS(0)) uut (
        .clk(clk), .rst_n(rst_n), .addr_strobe(bale), .sys_addr(sa), .upper_addr(la),
        .dma_active(dma), .mem_rd_n(mrd), .mem_wr_n(mwr), .io_rd_n(ird), .io_wr_n(iwr),
        .wide_xfer(wide), .data_in(sd_in), .data_out(dout_m), .data_oe_lo(oel_m),
        .data_oe_hi(oeh_m), .ready_pull(pull_m), .zero_wait_req(zws_m),
        .irq_event(ev_m), .irq_req(irq_m));

    isa_slave_port #(.IS_MEM(1'b0), .BASE_ADDR(IBASE), .WAIT_CLKS(3)) uut_io (
        .clk(clk), .rst_n(rst_n), .addr_strobe(bale), .sys_addr(sa), .upper_addr(la),
        .dma_active(dma), .mem_rd_n(mrd), .mem_wr_n(mwr), .io_rd_n(ird), .io_wr_n(iwr),
        .wide_xfer(wide), .data_in(sd_in), .data_out(dout_i), .data_oe_lo(oel_i),
        .data_oe_hi(oeh_i), .ready_pull(pull_i), .zero_wait_req(zws_i),
        .irq_event(ev_i), .irq_req(irq_i));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic addr_phase(input logic [23:0] a);
        @(negedge clk); bale = 1; sa = a[19:0]; la = a[23:17];
        @(negedge clk); bale = 0; sa = ~a[19:0]; la = ~a[23:17];
    endtask

    task automatic mem_write(input logic [23:0] a, input logic [15:0] d, input logic w, input logic dm);
        addr_phase(a);
        dma = dm; wide = w; sd_in = d; mwr = 0;
        @(negedge clk); mwr = 1; dma = 0;
    endtask

    task automatic mem_read(input logic [23:0] a, input logic w,
                            output logic [15:0] d, output logic lo, output logic hi, output logic z);
        addr_phase(a);
        wide = w; mrd = 0;
        #1; d = dout_m; lo = oel_m; hi = oeh_m; z = zws_m;
        @(negedge clk); #1;
        chk("R7 oe held through command", {oel_m, oeh_m}, {lo, hi});
        mrd = 1; #1;
        chk("R7 oe drop at strobe end", {oel_m, oeh_m}, 2'b00);
    endtask

    task automatic io_write(input logic [23:0] a, input logic [15:0] d, input logic w);
        addr_phase(a);
        wide = w; sd_in = d; iwr = 0;
        #1;
        for (int k = 0; k < 20 && pull_i; k++) begin @(negedge clk); #1; end
        iwr = 1;
    endtask

    task automatic io_read(input logic [23:0] a, input logic w,
                           output logic [15:0] d, output int cnt, output logic lo, output logic hi);
        addr_phase(a);
        wide = w; ird = 0; cnt = 0;
        #1;
        while (pull_i && cnt < 20) begin cnt++; @(negedge clk); #1; end
        d = dout_i; lo = oel_i; hi = oeh_i;
        ird = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic lo, hi, z;
        int cnt;
        logic [23:0] a;
        logic exp_sel;

        for (int i = 0; i < 8; i++) begin exp_m[i] = 0; exp_i[i] = 0; end
        repeat (3) @(negedge clk);
        #1;
        chk("R10 reset outputs", {oel_m, oeh_m, pull_m, zws_m, irq_m, oel_i, pull_i, irq_i}, 8'h00);
        rst_n = 1;

        // R10: registers read zero after reset
        mem_read(MBASE + 24'd3, 1'b1, d, lo, hi, z);
        chk("R10 reg zero", d, 16'h0000);

        // R2 / R6: sweep the memory window edges
        for (int o = -3; o < 11; o++) begin
            a = MBASE + 24'(o);
            exp_sel = (o >= 0 && o < 8);
            mem_read(a, 1'b1, d, lo, hi, z);
            chk("R2 mem select edge", lo, exp_sel);
            chk("R6 zws mem", z, exp_sel);
            chk("R3 io card silent on mem strobe", {oel_i, pull_i}, 2'b00);
        end
        // R2: single-bit flips in upper and low groups
        foreach (a[i]) if (i >= 3) begin
            mem_read(MBASE ^ (24'd1 << i), 1'b1, d, lo, hi, z);
            chk("R2 mem bit flip deselects", {lo, z}, 2'b00);
        end

        // R3 / R5 / R6: sweep the I/O window
        for (int o = -4; o < 12; o++) begin
            a = IBASE + 24'(o);
            exp_sel = (o >= 0 && o < 8);
            addr_phase(a);
            ird = 0; #1;
            chk("R5 pull same cycle as command", pull_i, exp_sel);
            chk("R3 io select edge", oel_i, exp_sel);
            chk("R6 no zws in io mode", zws_i, 1'b0);
            @(negedge clk); ird = 1;
        end
        // R3: bits 19..16 are ignored by the I/O decode
        io_read(IBASE | 24'h0A0000, 1'b1, d, cnt, lo, hi);
        chk("R3 io ignores high bits", lo, 1'b1);
        // R3: memory strobe at an I/O address does nothing for the I/O card
        mem_read(IBASE, 1'b1, d, lo, hi, z);
        chk("R3 io card ignores mem strobe", {oel_i, pull_i}, 2'b00);

        // R8: wide writes on both cards
        for (int i = 0; i < 8; i++) begin
            exp_m[i] = 16'hA000 + 16'(i) * 16'h0111;
            mem_write(MBASE + 24'(i), exp_m[i], 1'b1, 1'b0);
            exp_i[i] = 16'h5A00 ^ (16'(i) << 9) ^ 16'(i);
            io_write(IBASE + 24'(i), exp_i[i], 1'b1);
        end
        for (int i = 0; i < 8; i++) begin
            mem_read(MBASE + 24'(i), 1'b1, d, lo, hi, z);
            chk("R8 mem wide readback", d, exp_m[i]);
            io_read(IBASE + 24'(i), 1'b1, d, cnt, lo, hi);
            chk("R8 io wide readback", d, exp_i[i]);
            chk("R5 io wait length", cnt, 3);
        end

        // R8: narrow write keeps the high byte
        mem_write(MBASE + 24'd2, 16'h55CC, 1'b0, 1'b0);
        exp_m[2] = {exp_m[2][15:8], 8'hCC};
        mem_read(MBASE + 24'd2, 1'b1, d, lo, hi, z);
        chk("R8 narrow write", d, exp_m[2]);
        // R7: narrow read drives only the low lane
        mem_read(MBASE + 24'd2, 1'b0, d, lo, hi, z);
        chk("R7 narrow read lanes", {lo, hi}, 2'b10);
        chk("R7 narrow read data", d, {8'h00, exp_m[2][7:0]});
        mem_read(MBASE + 24'd4, 1'b1, d, lo, hi, z);
        chk("R7 wide read lanes", {lo, hi}, 2'b11);

        // R1: address scrambled after the strobe fall (done in every addr_phase); index held
        mem_read(MBASE + 24'd5, 1'b1, d, lo, hi, z);
        chk("R1 latched index", d, exp_m[5]);

        // R4: DMA-flagged write and read
        mem_write(MBASE + 24'd1, 16'hDEAD, 1'b1, 1'b1);
        addr_phase(MBASE + 24'd1);
        dma = 1; mrd = 0; #1;
        chk("R4 no drive under dma", {oel_m, zws_m, pull_m}, 3'b000);
        @(negedge clk); mrd = 1; dma = 0;
        mem_read(MBASE + 24'd1, 1'b1, d, lo, hi, z);
        chk("R4 dma write not stored", d, exp_m[1]);

        // R9: interrupt raise, hold, clear, re-arm
        @(negedge clk); ev_m = 1; @(negedge clk); ev_m = 0; #1;
        chk("R9 irq raised", irq_m, 1'b1);
        repeat (4) @(negedge clk); #1;
        chk("R9 irq held", irq_m, 1'b1);
        mem_write(MBASE + 24'd6, 16'h1234, 1'b1, 1'b0);
        exp_m[6] = 16'h1234;
        #1;
        chk("R9 other index does not clear", irq_m, 1'b1);
        addr_phase(MBASE + 24'd7);
        wide = 1; sd_in = 16'h0007; mwr = 0; ev_m = 1;
        @(negedge clk); mwr = 1; #1;
        chk("R9 clear beats event", irq_m, 1'b0);
        @(negedge clk); ev_m = 0; #1;
        chk("R9 re-arm after low clock", irq_m, 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule